// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Controller

This block turns single read or write requests from a 16-bit core into bus cycles on a shared address/data bus toward external memory. A request carries an address, write data, a byte-or-word size and a direction. The controller places the address on the shared lines and marks it with an address strobe. It then drives a read strobe, or write strobes with the write data. It finishes with a one-clock completion phase in which it raises `ack` toward the core. For reads, `rdata` is valid in that phase.

Static configuration inputs select five things: how the address strobe looks, how the write strobes are split, which bus width is used, how many wait states a slow memory may request through `bus_ready`, and whether a compatibility timing mode adds one wait state to every cycle. A word request on an 8-bit bus becomes two byte cycles, and the core sees a single `ack`. In this block one clock equals one oscillator period. A basic cycle takes 4 clocks, and every wait state adds 2 clocks.

Top module: `ext_bus_ctrl`

## Requirements
- R1: A bus cycle has three parts. The address clock comes first: `ad_out` carries the address and `ad_oe`=1. Two strobe clocks follow, plus 2 more per wait state. The last part is one end clock, in which the strobes are high (inactive) and, for the final byte, `ack`=1 with read data on `rdata`. Without waits, a cycle takes 4 clocks.
- R2: `cfg_wait` caps the waits that `bus_ready` can add: 000 allows none, 001 allows 1, 010 allows 2 and 011 allows 3. With bit 2 set there is no cap, and waits continue for as long as `bus_ready` is low.
- R3: `bus_ready` is sampled at the clock edge that ends each pair of strobe clocks. If it is low and the cap is not reached, one more strobe pair of 2 clocks follows.
- R4: With `cfg_compat`=1, the first strobe pair is always followed by one wait, whatever `bus_ready` shows. Only the decisions after it count against the `cfg_wait` cap.
- R5: `cfg_width` selects the bus width: 01 = 16-bit, 10 = 8-bit, 11 = the value of `bus_wide` when the request is accepted (1 = 16-bit, 0 = 8-bit).
- R6: `cfg_width`=00 is handled as 16-bit. Accepting a request under this code sets `cfg_err`, which stays set until reset.
- R7: On the 8-bit bus, a word request becomes two byte cycles. The even address comes first, with data byte [7:0], then the odd address with data byte [15:8]. Both bytes travel on `ad[7:0]`, and there is one `ack` after the second cycle. A word address is always forced even.
- R8: On the 16-bit bus, the high-byte enable (`hb_n` when `cfg_wr_mode`=1) is low for a word access or an odd address, and high for an even byte access. It is low through the whole cycle. A byte read returns the lane chosen by A0 in `rdata[7:0]`, with `rdata[15:8]`=0. On the 8-bit bus the enable stays high.
- R9: With `cfg_wr_mode`=1, `wr_n` strobes on every write and `hb_n` is the high-byte enable. With `cfg_wr_mode`=0, `wr_n` strobes only when the low (even) byte is written and `hb_n` only when the high (odd) byte is written. `rd_n` and `wr_n` are never low together.
- R10: With `cfg_ale_mode`=1, `addr_strb` is high only in the address clock. With `cfg_ale_mode`=0, `addr_strb` is an active-low address-valid signal that is low from the address clock through the end clock, and high at idle.
- R11: `req_ready`=1 only while idle. A request is taken when `req_valid`=1 and `req_ready`=1, and its address clock follows on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one oscillator period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data (byte writes use [7:0]) |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_write | input | 1 | 1 = write, 0 = read |
| ack | output | 1 | Access complete, one clock |
| rdata | output | 16 | Read data, valid with ack |
| cfg_wait | input | 3 | Wait-state cap code |
| cfg_width | input | 2 | Bus width policy code |
| cfg_compat | input | 1 | Add one mandatory wait per cycle |
| cfg_ale_mode | input | 1 | 1 = latch pulse, 0 = address-valid level |
| cfg_wr_mode | input | 1 | 1 = write plus high-byte enable, 0 = split low/high write strobes |
| cfg_err | output | 1 | Sticky illegal width code flag |
| bus_ready | input | 1 | Memory ready, low requests waits |
| bus_wide | input | 1 | Per-cycle bus width pin, 1 = 16-bit |
| ad_in | input | 16 | Data read from the shared lines |
| ad_out | output | 16 | Address or write data onto the shared lines |
| ad_oe | output | 1 | Output enable for ad_out |
| addr_strb | output | 1 | Address strobe, form set by cfg_ale_mode |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write or low-byte write strobe, active low |
| hb_n | output | 1 | High-byte enable or high-byte write strobe, active low |

## Verification
The hardest case to reach is the wait decision when several limits act at once. Examples are a compatibility-mode cycle whose mandatory wait is followed by ready-driven waits against a nonzero cap, and an 8-bit split word whose two byte cycles each make their own ready decisions. The bench drives `bus_ready` from a count of low samples: it holds ready low for the first N strobe-pair decisions of a request and high afterwards. N is chosen below, at and above the cap, so that the cap, the unlimited code and the mandatory wait each decide the cycle length. Every such request is replayed in a behavioural model that predicts every clock of the strobes and of the shared lines.

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_wdata,
  input  logic        req_word,
  input  logic        req_write,
  output logic        ack,
  output logic [15:0] rdata,
  input  logic [2:0]  cfg_wait,
  input  logic [1:0]  cfg_width,
  input  logic        cfg_compat,
  input  logic        cfg_ale_mode,
  input  logic        cfg_wr_mode,
  output logic        cfg_err,
  input  logic        bus_ready,
  input  logic        bus_wide,
  input  logic [15:0] ad_in,
  output logic [15:0] ad_out,
  output logic        ad_oe,
  output logic        addr_strb,
  output logic        rd_n,
  output logic        wr_n,
  output logic        hb_n
);

  typedef enum logic [1:0] {PH_ADDR, PH_STRA, PH_STRB, PH_END} ph_t;

  ph_t         ph;
  logic        busy, wr_q, w16_q, split_q, narrow_q, hi_q, mand_q;
  logic [1:0]  rw_q;
  logic [15:0] addr_q, wd_q;
  logic        eff16;

  always_comb
    case (cfg_width)
      2'b10:   eff16 = 1'b0;
      2'b11:   eff16 = bus_wide;
      default: eff16 = 1'b1;
    endcase

  wire        take      = req_valid && !busy;
  wire [15:0] cur_addr  = (split_q && hi_q) ? {addr_q[15:1], 1'b1} : addr_q;
  wire [7:0]  cur_byte  = (split_q && hi_q) ? wd_q[15:8] : wd_q[7:0];
  wire        lo_lane   = w16_q || !cur_addr[0];
  wire        hi_lane   = w16_q || cur_addr[0];
  wire        bhe_n     = narrow_q || !hi_lane;
  wire        strobe    = busy && (ph == PH_STRA || ph == PH_STRB);
  wire        mand_wait = cfg_compat && !mand_q;
  wire        rdy_wait  = !bus_ready && (cfg_wait[2] || rw_q < cfg_wait[1:0]);
  wire        last      = !split_q || hi_q;

  assign req_ready = !busy;
  assign ack       = busy && ph == PH_END && last;
  assign rd_n      = !(strobe && !wr_q);
  assign wr_n      = !(strobe && wr_q && (cfg_wr_mode || lo_lane));
  assign hb_n      = cfg_wr_mode ? (!busy || bhe_n) : !(strobe && wr_q && hi_lane);
  assign addr_strb = cfg_ale_mode ? (busy && ph == PH_ADDR) : !busy;
  assign ad_oe     = busy && (ph == PH_ADDR || wr_q);
  assign ad_out    = (ph == PH_ADDR) ? cur_addr : (w16_q ? wd_q : {cur_byte, cur_byte});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;  ph <= PH_ADDR;  wr_q <= 1'b0;  w16_q <= 1'b0;
      split_q <= 1'b0;  narrow_q <= 1'b0;  hi_q <= 1'b0;  mand_q <= 1'b0;
      rw_q <= 2'd0;  addr_q <= 16'h0;  wd_q <= 16'h0;  rdata <= 16'h0;
      cfg_err <= 1'b0;
    end else if (take) begin
      busy     <= 1'b1;
      ph       <= PH_ADDR;
      wr_q     <= req_write;
      w16_q    <= req_word && eff16;
      split_q  <= req_word && !eff16;
      narrow_q <= !eff16;
      hi_q     <= 1'b0;
      addr_q   <= req_word ? {req_addr[15:1], 1'b0} : req_addr;
      wd_q     <= req_wdata;
      if (cfg_width == 2'b00) cfg_err <= 1'b1;
    end else if (busy) begin
      case (ph)
        PH_ADDR: begin
          ph     <= PH_STRA;
          mand_q <= 1'b0;
          rw_q   <= 2'd0;
        end
        PH_STRA: ph <= PH_STRB;
        PH_STRB:
          if (mand_wait || rdy_wait) begin
            ph <= PH_STRA;
            if (mand_wait) mand_q <= 1'b1;
            else if (rw_q != 2'd3) rw_q <= rw_q + 2'd1;
          end else begin
            ph <= PH_END;
            if (!wr_q) begin
              if (w16_q) rdata <= ad_in;
              else if (split_q) begin
                if (hi_q) rdata[15:8] <= ad_in[7:0];
                else      rdata[7:0]  <= ad_in[7:0];
              end else
                rdata <= {8'h00, (!narrow_q && cur_addr[0]) ? ad_in[15:8] : ad_in[7:0]};
            end
          end
        default:
          if (last) busy <= 1'b0;
          else begin
            hi_q <= 1'b1;
            ph   <= PH_ADDR;
          end
      endcase
    end

endmodule

// File: rtl/ext_bus_ctrl_chk.sv
module ext_bus_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       hb_n,
  input logic       ack,
  input logic       req_ready,
  input logic       cfg_err,
  input logic [2:0] cfg_wait,
  input logic       cfg_compat,
  input logic       cfg_wr_mode,
  input logic       cfg_ale_mode,
  input logic       addr_strb,
  input logic       ad_oe
);

  logic [7:0] len;
  wire act = !rd_n || !wr_n || (!cfg_wr_mode && !hb_n);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) len <= 8'd0;
    else if (act) len <= (len == 8'hFF) ? len : len + 8'd1;
    else len <= 8'd0;

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R9
  AST_ACK_STROBES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (rd_n && wr_n)); // R1
  AST_WAIT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !cfg_wait[2] && !cfg_compat) |-> (len < 8'd2 + {5'd0, cfg_wait[1:0], 1'b0})); // R2
  AST_COMPAT_MIN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_compat && !act && len != 8'd0) |-> (len >= 8'd4)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err); // R6
  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (rd_n && wr_n && !ad_oe)); // R11
  AST_LATCH_PULSE_APART: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ale_mode && addr_strb) |-> (rd_n && wr_n)); // R10

endmodule

bind ext_bus_ctrl ext_bus_ctrl_chk u_chk (.*);

// File: tb/ext_bus_ctrl_test.sv
module ext_bus_ctrl_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_word = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = 16'h0, req_wdata = 16'h0, ad_in = 16'h0;
  logic [2:0] cfg_wait = 3'b000;
  logic [1:0] cfg_width = 2'b01;
  logic cfg_compat = 1'b0, cfg_ale_mode = 1'b1, cfg_wr_mode = 1'b1;
  logic bus_ready = 1'b1, bus_wide = 1'b1;
  logic req_ready, ack, cfg_err, ad_oe, addr_strb, rd_n, wr_n, hb_n;
  logic [15:0] rdata, ad_out;
  int checks = 0, errors = 0;
  bit done = 0;

  ext_bus_ctrl uut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic expect_pins(input string tag, input bit e_as, e_rd, e_wr, e_hb, e_oe,
                             input logic [15:0] e_ad, input bit e_ack);
    check(tag, "addr_strb", addr_strb, e_as);
    check(tag, "rd_n", rd_n, e_rd);
    check(tag, "wr_n", wr_n, e_wr);
    check(tag, "hb_n", hb_n, e_hb);
    check(tag, "ad_oe", ad_oe, e_oe);
    if (e_oe) check(tag, "ad_out", ad_out, e_ad);
    check(tag, "ack", ack, e_ack);
  endtask

  task automatic txn(input string tag, input bit wr, input bit word, input logic [15:0] addr,
                     input logic [15:0] wdata, input logic [15:0] rword, input bit pin, input int nlow);
    bit narrow, split, w16, mand, fin, rdy, lst, lo, hi, bhe, hbc, e_wr, e_hb;
    int nb, lowcnt, rw;
    logic [15:0] a, dat;
    logic [7:0] byt;
    check({tag, " R11"}, "req_ready idle", req_ready, 1);
    req_valid = 1; req_write = wr; req_word = word; req_addr = addr;
    req_wdata = wdata; bus_wide = pin;
    narrow = (cfg_width == 2'b10) || (cfg_width == 2'b11 && !pin);
    split = word && narrow;
    w16 = word && !narrow;
    nb = split ? 2 : 1;
    lowcnt = 0;
    @(negedge clk);
    req_valid = 0;
    for (int b = 0; b < nb; b++) begin
      a = word ? {addr[15:1], 1'b0} : addr;
      if (split && b == 1) a[0] = 1'b1;
      byt = (split && b == 1) ? wdata[15:8] : wdata[7:0];
      lo = w16 || !a[0];
      hi = w16 || a[0];
      bhe = narrow || !hi;
      hbc = cfg_wr_mode ? bhe : 1'b1;
      dat = w16 ? wdata : {byt, byt};
      e_wr = wr ? !(cfg_wr_mode || lo) : 1'b1;
      e_hb = cfg_wr_mode ? bhe : (wr ? !hi : 1'b1);
      expect_pins(tag, cfg_ale_mode, 1, 1, hbc, 1, a, 0);
      @(negedge clk);
      mand = cfg_compat; rw = 0; fin = 0;
      while (!fin) begin
        expect_pins(tag, 0, wr, e_wr, e_hb, wr, dat, 0);
        @(negedge clk);
        expect_pins(tag, 0, wr, e_wr, e_hb, wr, dat, 0);
        rdy = (lowcnt < nlow) ? 1'b0 : 1'b1;
        lowcnt++;
        bus_ready = rdy;
        if (narrow)
          ad_in = {8'h5A, split ? (b == 1 ? rword[15:8] : rword[7:0])
                                : (a[0] ? rword[15:8] : rword[7:0])};
        else
          ad_in = rword;
        if (mand) mand = 0;
        else if (!rdy && (cfg_wait[2] || rw < int'(cfg_wait[1:0]))) rw++;
        else fin = 1;
        @(negedge clk);
      end
      bus_ready = 1;
      lst = (b == nb - 1);
      expect_pins(tag, 0, 1, 1, hbc, wr, dat, lst);
      if (lst && !wr)
        check(tag, "rdata", rdata, word ? rword : {8'h00, addr[0] ? rword[15:8] : rword[7:0]});
      @(negedge clk);
    end
    check({tag, " R10"}, "addr_strb idle", addr_strb, !cfg_ale_mode);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset", "rd_n", rd_n, 1);
    check("R1 reset", "wr_n", wr_n, 1);
    check("R9 reset", "hb_n", hb_n, 1);
    check("R1 reset", "ad_oe", ad_oe, 0);
    check("R1 reset", "ack", ack, 0);
    check("R11 reset", "req_ready", req_ready, 1);
    check("R6 reset", "cfg_err", cfg_err, 0);
    check("R10 reset", "addr_strb", addr_strb, 0);
    @(negedge clk);

    txn("R1/R2 cap0", 0, 1, 16'h1234, 16'h0, 16'hBEEF, 1, 3);
    cfg_wait = 3'b010; txn("R2 cap2", 0, 1, 16'h2000, 16'h0, 16'hCAFE, 1, 5);
    cfg_wait = 3'b100; txn("R2/R3 unlimited", 0, 1, 16'h2002, 16'h0, 16'h1357, 1, 3);
    cfg_wait = 3'b011; txn("R3 one low", 1, 1, 16'h3004, 16'hA1B2, 16'h0, 1, 1);
    cfg_compat = 1; cfg_wait = 3'b001;
    txn("R4 compat+ready", 0, 1, 16'h4000, 16'h0, 16'h2468, 1, 2);
    cfg_wait = 3'b000;
    txn("R4 compat only", 1, 1, 16'h4010, 16'h5566, 16'h0, 1, 0);
    cfg_compat = 0;
    txn("R8/R9 byte even wr", 1, 0, 16'h5010, 16'h00C3, 16'h0, 1, 0);
    txn("R8/R9 byte odd wr", 1, 0, 16'h5011, 16'h003C, 16'h0, 1, 0);
    txn("R8 byte odd rd", 0, 0, 16'h5013, 16'h0, 16'h9A7E, 1, 0);
    txn("R8 byte even rd", 0, 0, 16'h5014, 16'h0, 16'h9A7E, 1, 0);
    cfg_wr_mode = 0;
    txn("R9 split word wr", 1, 1, 16'h6021, 16'h7788, 16'h0, 1, 0);
    txn("R9 split even wr", 1, 0, 16'h6022, 16'h0011, 16'h0, 1, 0);
    txn("R9 split odd wr", 1, 0, 16'h6023, 16'h0022, 16'h0, 1, 0);
    cfg_wr_mode = 1; cfg_width = 2'b10; cfg_wait = 3'b001;
    txn("R7 narrow word rd", 0, 1, 16'h7001, 16'h0, 16'hD00D, 1, 1);
    txn("R7 narrow word wr", 1, 1, 16'h7100, 16'hF00D, 16'h0, 1, 3);
    txn("R7 narrow byte rd", 0, 0, 16'h7203, 16'h0, 16'h4455, 1, 0);
    cfg_wr_mode = 0;
    txn("R7/R9 narrow wr split strobes", 1, 1, 16'h7300, 16'hABCD, 16'h0, 1, 0);
    cfg_wr_mode = 1; cfg_width = 2'b11;
    txn("R5 pin narrow", 0, 1, 16'h8000, 16'h0, 16'h6789, 0, 0);
    txn("R5 pin wide", 0, 1, 16'h8002, 16'h0, 16'h6789, 1, 0);
    cfg_ale_mode = 0;
    txn("R10 valid strobe", 0, 1, 16'h9000, 16'h0, 16'h1111, 1, 1);
    txn("R10 valid narrow", 1, 1, 16'h9100, 16'h2233, 16'h0, 0, 0);
    cfg_ale_mode = 1;
    check("R6 before", "cfg_err", cfg_err, 0);
    cfg_width = 2'b00;
    txn("R6 illegal as wide", 0, 1, 16'hA000, 16'h0, 16'h0F0F, 0, 0);
    check("R6 set", "cfg_err", cfg_err, 1);
    cfg_width = 2'b01;
    txn("R6 sticky", 1, 0, 16'hA001, 16'h0099, 16'h0, 1, 0);
    check("R6 sticky", "cfg_err", cfg_err, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule